// File: doc/BRIEF.md
# SD Host Single-Segment DMA Engine

This block moves one contiguous buffer between system memory and the data port of an SD/SDIO host. Software works through a register window of 64-bit words. It programs a mode word, which holds the direction channel, a bus-width field and the address step. It then loads an 8-byte-aligned start address and writes a start bit. The length in bytes comes from the host data port on `xfer_len`. The engine moves `xfer_len / 8` beats of 8 bytes each, one at a time. Channel 0 reads memory and streams the words toward the card. Channel 1 takes words from the card and writes them to memory.

Each channel has its own end flag in the first status word and its own error flag in the second. Each status word has a 32-bit mask. An interrupt line for a status word is high while any of its flags is set and not masked. Each channel also has an active-low soft reset bit. While that bit is low, the channel is held idle and any transfer it is running is dropped.

All three data interfaces use valid/ready. A beat passes on a clock edge where both valid and ready are high. The engine keeps `mem_req_*` and `tx_data` stable while their valid is high and ready is low. The one exception is a soft reset of the active channel: valid then drops without a handshake. Memory read responses arrive on `mem_rsp_valid` and cannot be back-pressured. `rx_ready` is high only while the engine waits for a word from the card.

Top module: `sdh_dma_engine`

## Requirements
- R1: After reset, the register words read as follows: mode 0, soft-reset word 0x300, both status words 0 and both masks 0xFFFFFFFF. `busy`, `irq_end`, `irq_err` and every valid/ready output driven by the engine are low.
- R2: The register word offsets are mode 0x820, start 0x828, soft reset 0x830, end status 0x840, end mask 0x848, error status 0x850, error mask 0x858 and start address 0x880. The mode word reads back its channel bit 16, its width field in bits 5:4 and its step bit 0. The address word reads back the value that was written.
- R3: A channel 0 start (mode bit 16 = 0) makes `xfer_len/8` memory reads (`mem_req_we`=0). The read data goes out on `tx_data` in address order, one word per read.
- R4: A channel 1 start (mode bit 16 = 1) takes `xfer_len/8` words from `rx_data`. It writes each word to memory (`mem_req_we`=1) in arrival order.
- R5: With mode bit 0 set to 1, beat k uses address start+8k. With bit 0 set to 0, every beat uses the start address.
- R6: When the last beat is accepted, the engine goes idle and sets end flag bit 16+ch of the end status word. A start with `xfer_len/8` = 0 sets that flag at once and moves no data.
- R7: A start whose address has bits 2:0 not zero sets error flag bit 16+ch of the error status word. It moves no data and issues no memory request.
- R8: A memory read response with `mem_rsp_err` high stops a channel 0 transfer. It sets error bit 16 and leaves the end flag clear.
- R9: A write to a status word keeps each flag only where the written bit is 1, so writing 0 clears every flag. A flag set in the same cycle wins over the clear.
- R10: `irq_end` is high exactly when some bit is set in the low 32 bits of the end status word and the same bit is clear in the end mask. `irq_err` behaves the same way for the error status word and the error mask.
- R11: Soft-reset bit 8 (channel 0) and bit 9 (channel 1) are active low. While a bit is 0, a start on that channel is ignored. A transfer running on that channel is dropped without setting any flag, and `busy` falls within two cycles.
- R12: A start written while `busy` is high is ignored. Memory requests and `tx_data` hold steady under back-pressure until they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| xfer_len | input | 32 | Transfer length in bytes from the host data port |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 40 | Memory byte address, 8-byte aligned |
| mem_req_wdata | output | 64 | Memory write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| tx_valid | output | 1 | Word toward card valid |
| tx_ready | input | 1 | Card side accepts word |
| tx_data | output | 64 | Word toward card |
| rx_valid | input | 1 | Word from card valid |
| rx_ready | output | 1 | Engine accepts word from card |
| rx_data | input | 64 | Word from card |
| busy | output | 1 | A transfer is in progress |
| irq_end | output | 1 | Unmasked end flag present |
| irq_err | output | 1 | Unmasked error flag present |

## Verification
On every cycle, the assertions check four properties. Requests and card-bound words hold steady under back-pressure unless the active channel is being reset. Every memory address is 8-byte aligned. Nothing is requested or offered while the engine is idle. A fully masked status word never raises its interrupt. The bench scenarios are what show the data and the order of the beats in both directions, and the fixed-address mode. They also show that the flags land on the right channel after completion, a zero length, a misaligned start and a read error. They also cover clear-by-write, the dropping of a transfer by soft reset, and starts that are ignored while busy or while the channel is held in reset.

// File: rtl/sdh_dma_pkg.sv
package sdh_dma_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_MODE = 12'h820;
  localparam logic [OFS_W-1:0] OFS_CTRL = 12'h828;
  localparam logic [OFS_W-1:0] OFS_RST  = 12'h830;
  localparam logic [OFS_W-1:0] OFS_ST1  = 12'h840;
  localparam logic [OFS_W-1:0] OFS_MSK1 = 12'h848;
  localparam logic [OFS_W-1:0] OFS_ST2  = 12'h850;
  localparam logic [OFS_W-1:0] OFS_MSK2 = 12'h858;
  localparam logic [OFS_W-1:0] OFS_ADDR = 12'h880;

  localparam int NCH      = 2;   // channel select is one bit
  localparam int BIT_CH   = 16;
  localparam int BIT_BW   = 4;
  localparam int BIT_INC  = 0;
  localparam int BIT_RST  = 8;
  localparam int BIT_FLAG = 16;
  localparam int MSK_W    = 32;
  localparam int BEAT_B   = 8;   // bytes per beat
  localparam int BEAT_SH  = 3;

  typedef struct packed {
    logic       ch;
    logic [1:0] bw;
    logic       inc;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_TX, ST_RX, ST_WR
  } seq_st_e;
endpackage

// File: rtl/sdh_dma_regs.sv
module sdh_dma_regs
  import sdh_dma_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [OFS_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NCH-1:0]       end_flags,
  input  logic [NCH-1:0]       err_flags,
  output mode_t                mode_q,
  output logic [ADDR_W-1:0]    start_addr,
  output logic                 start_pulse,
  output logic [NCH-1:0]       chan_run,
  output logic [MSK_W-1:0]     mask1,
  output logic [MSK_W-1:0]     mask2,
  output logic                 st1_wr,
  output logic                 st2_wr
);
  logic hit_mode, hit_rst, hit_addr, hit_m1, hit_m2;

  assign hit_mode    = reg_wr && (reg_addr == OFS_MODE);
  assign hit_rst     = reg_wr && (reg_addr == OFS_RST);
  assign hit_addr    = reg_wr && (reg_addr == OFS_ADDR);
  assign hit_m1      = reg_wr && (reg_addr == OFS_MSK1);
  assign hit_m2      = reg_wr && (reg_addr == OFS_MSK2);
  assign st1_wr      = reg_wr && (reg_addr == OFS_ST1);
  assign st2_wr      = reg_wr && (reg_addr == OFS_ST2);
  assign start_pulse = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      start_addr <= '0;
      chan_run   <= '1;
      mask1      <= '1;
      mask2      <= '1;
    end else begin
      if (hit_mode) begin
        mode_q.ch  <= reg_wdata[BIT_CH];
        mode_q.bw  <= reg_wdata[BIT_BW +: 2];
        mode_q.inc <= reg_wdata[BIT_INC];
      end
      if (hit_addr) start_addr <= reg_wdata[ADDR_W-1:0];
      if (hit_rst)  chan_run   <= reg_wdata[BIT_RST +: NCH];
      if (hit_m1)   mask1      <= reg_wdata[MSK_W-1:0];
      if (hit_m2)   mask2      <= reg_wdata[MSK_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_MODE: begin
        reg_rdata[BIT_CH]      = mode_q.ch;
        reg_rdata[BIT_BW +: 2] = mode_q.bw;
        reg_rdata[BIT_INC]     = mode_q.inc;
      end
      OFS_RST:  reg_rdata[BIT_RST +: NCH]  = chan_run;
      OFS_ST1:  reg_rdata[BIT_FLAG +: NCH] = end_flags;
      OFS_ST2:  reg_rdata[BIT_FLAG +: NCH] = err_flags;
      OFS_MSK1: reg_rdata[MSK_W-1:0]       = mask1;
      OFS_MSK2: reg_rdata[MSK_W-1:0]       = mask2;
      OFS_ADDR: reg_rdata[ADDR_W-1:0]      = start_addr;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_dma_status.sv
module sdh_dma_status
  import sdh_dma_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     set_end,
  input  logic [NCH-1:0]     set_err,
  input  logic               st1_wr,
  input  logic               st2_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [MSK_W-1:0]   mask1,
  input  logic [MSK_W-1:0]   mask2,
  output logic [NCH-1:0]     end_flags,
  output logic [NCH-1:0]     err_flags,
  output logic               irq_end,
  output logic               irq_err
);
  logic [MSK_W-1:0] vec1, vec2;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        end_flags[i] <= 1'b0;
        err_flags[i] <= 1'b0;
      end else begin
        if (set_end[i])  end_flags[i] <= 1'b1;
        else if (st1_wr) end_flags[i] <= end_flags[i] & wdata[BIT_FLAG+i];
        if (set_err[i])  err_flags[i] <= 1'b1;
        else if (st2_wr) err_flags[i] <= err_flags[i] & wdata[BIT_FLAG+i];
      end
    end
  end

  always_comb begin
    vec1 = '0;
    vec2 = '0;
    vec1[BIT_FLAG +: NCH] = end_flags;
    vec2[BIT_FLAG +: NCH] = err_flags;
  end

  assign irq_end = |(vec1 & ~mask1);
  assign irq_err = |(vec2 & ~mask2);
endmodule

// File: rtl/sdh_dma_seq.sv
module sdh_dma_seq
  import sdh_dma_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_pulse,
  input  mode_t              mode_q,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [LEN_W-1:0]   xfer_len,
  input  logic [NCH-1:0]     chan_run,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [DATA_W-1:0]  tx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               busy,
  output logic               act_run,
  output logic [NCH-1:0]     set_end,
  output logic [NCH-1:0]     set_err
);
  localparam int CNT_W = LEN_W - BEAT_SH;

  seq_st_e           st;
  logic              ch_q, inc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic [DATA_W-1:0] data_q;

  logic [CNT_W-1:0]  beats;
  logic              start_ok, misalign, last, tx_hs, wr_hs, rd_bad;
  logic [ADDR_W-1:0] addr_nx;

  assign beats    = xfer_len[LEN_W-1:BEAT_SH];
  assign misalign = |start_addr[BEAT_SH-1:0];
  assign start_ok = start_pulse && (st == ST_IDLE) && chan_run[mode_q.ch];
  assign act_run  = chan_run[ch_q];
  assign last     = (remain_q == CNT_W'(1));
  assign addr_nx  = addr_q + (inc_q ? ADDR_W'(BEAT_B) : '0);

  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = act_run && ((st == ST_RD_REQ) || (st == ST_WR));
  assign mem_req_we    = (st == ST_WR);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = data_q;
  assign tx_valid      = act_run && (st == ST_TX);
  assign tx_data       = data_q;
  assign rx_ready      = act_run && (st == ST_RX);

  assign tx_hs  = tx_valid && tx_ready;
  assign wr_hs  = mem_req_valid && mem_req_we && mem_req_ready;
  assign rd_bad = act_run && (st == ST_RD_WAIT) && mem_rsp_valid && mem_rsp_err;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      set_end[i] = (start_ok && !misalign && (beats == '0) && (int'(mode_q.ch) == i)) ||
                   (last && (tx_hs || wr_hs) && (int'(ch_q) == i));
      set_err[i] = (start_ok && misalign && (int'(mode_q.ch) == i)) ||
                   (rd_bad && (int'(ch_q) == i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ch_q     <= 1'b0;
      inc_q    <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      data_q   <= '0;
    end else if ((st != ST_IDLE) && !act_run) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_ok && !misalign && (beats != '0)) begin
            ch_q     <= mode_q.ch;
            inc_q    <= mode_q.inc;
            addr_q   <= start_addr;
            remain_q <= beats;
            st       <= mode_q.ch ? ST_RX : ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) st <= ST_IDLE;
            else begin
              data_q <= mem_rsp_data;
              st     <= ST_TX;
            end
          end
        end
        ST_TX: begin
          if (tx_ready) begin
            if (last) st <= ST_IDLE;
            else begin
              remain_q <= remain_q - CNT_W'(1);
              addr_q   <= addr_nx;
              st       <= ST_RD_REQ;
            end
          end
        end
        ST_RX: begin
          if (rx_valid) begin
            data_q <= rx_data;
            st     <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_req_ready) begin
            if (last) st <= ST_IDLE;
            else begin
              remain_q <= remain_q - CNT_W'(1);
              addr_q   <= addr_nx;
              st       <= ST_RX;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdh_dma_engine.sv
module sdh_dma_engine
  import sdh_dma_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [OFS_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [LEN_W-1:0]   xfer_len,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [DATA_W-1:0]  tx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               busy,
  output logic               irq_end,
  output logic               irq_err
);
  mode_t             mode_q;
  logic [ADDR_W-1:0] start_addr;
  logic              start_pulse, st1_wr, st2_wr, act_run;
  logic [NCH-1:0]    chan_run, end_flags, err_flags, set_end, set_err;
  logic [MSK_W-1:0]  mask1, mask2;

  sdh_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .end_flags(end_flags), .err_flags(err_flags),
    .mode_q(mode_q), .start_addr(start_addr), .start_pulse(start_pulse),
    .chan_run(chan_run), .mask1(mask1), .mask2(mask2),
    .st1_wr(st1_wr), .st2_wr(st2_wr)
  );

  sdh_dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .mode_q(mode_q),
    .start_addr(start_addr), .xfer_len(xfer_len), .chan_run(chan_run),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .act_run(act_run), .set_end(set_end), .set_err(set_err)
  );

  sdh_dma_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_end(set_end), .set_err(set_err),
    .st1_wr(st1_wr), .st2_wr(st2_wr), .wdata(reg_wdata),
    .mask1(mask1), .mask2(mask2), .end_flags(end_flags),
    .err_flags(err_flags), .irq_end(irq_end), .irq_err(irq_err)
  );
endmodule

// File: rtl/sdh_dma_chk.sv
module sdh_dma_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              act_run,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_ready,
  input logic [31:0]       mask1,
  input logic [31:0]       mask2,
  input logic              irq_end,
  input logic              irq_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (!act_run || (mem_req_valid &&
      $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)))); // R12

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!act_run || (tx_valid && $stable(tx_data)))); // R12

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !tx_valid && !rx_ready)); // R6

  AST_END_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask1) |-> !irq_end); // R10

  AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask2) |-> !irq_err); // R10
endmodule

bind sdh_dma_engine sdh_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .act_run(act_run),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_ready(rx_ready), .mask1(mask1), .mask2(mask2),
  .irq_end(irq_end), .irq_err(irq_err)
);

// File: tb/tb_sdh_dma_engine.sv
`timescale 1ns/1ps
module tb_sdh_dma_engine;
  localparam logic [11:0] A_MODE = 12'h820, A_CTRL = 12'h828, A_RST = 12'h830,
                          A_ST1 = 12'h840, A_MSK1 = 12'h848, A_ST2 = 12'h850,
                          A_MSK2 = 12'h858, A_ADDR = 12'h880;
  localparam logic [63:0] F0 = 64'h1_0000, F1 = 64'h2_0000;

  typedef struct {
    logic        we;
    logic [39:0] a;
    logic [63:0] d;
  } mem_item_t;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [31:0] xfer_len = '0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_we;
  logic [39:0] mem_req_addr;
  logic [63:0] mem_req_wdata, mem_rsp_data = '0, tx_data, rx_data = '0;
  logic mem_rsp_valid = 0, mem_rsp_err = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic busy, irq_end, irq_err;

  int errors = 0, checks = 0, cyc = 0;
  bit tx_stall = 0, rx_en = 1, rd_pend = 0, rx_pop = 0, done = 0;
  logic [39:0] rd_addr = '0, err_addr = 40'hFF_FFFF_FFF8;
  mem_item_t   exp_mem[$];
  logic [63:0] exp_tx[$];
  logic [63:0] rx_src[$];

  always #5 clk = ~clk;

  sdh_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_len(xfer_len),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .irq_end(irq_end), .irq_err(irq_err)
  );

  function automatic logic [63:0] mdata(logic [39:0] a);
    return {a[31:0] ^ 32'hA5A5_5A5A, ~a[31:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [63:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  // driver side of the scoreboard: expected items for each transfer
  task automatic push_ch0(logic [39:0] base, int n, bit inc);
    for (int i = 0; i < n; i++) begin
      logic [39:0] a;
      a = inc ? base + 40'(8 * i) : base;
      exp_mem.push_back('{1'b0, a, 64'd0});
      exp_tx.push_back(mdata(a));
    end
  endtask

  task automatic push_ch1(logic [39:0] base, int n, bit inc, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [39:0] a;
      logic [63:0] d;
      a = inc ? base + 40'(8 * i) : base;
      d = {seed + 32'(i), ~(seed + 32'(i))};
      rx_src.push_back(d);
      exp_mem.push_back('{1'b1, a, d});
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_drained(string tag);
    chk(exp_mem.size() == 0 && exp_tx.size() == 0, tag,
        64'(exp_mem.size() + exp_tx.size()), 64'd0);
  endtask

  // memory model, card model and monitor side of the scoreboard
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 0;
    mem_rsp_err   = 0;
    if (rd_pend) begin
      mem_rsp_valid = 1;
      mem_rsp_data  = mdata(rd_addr);
      mem_rsp_err   = (rd_addr == err_addr);
      rd_pend = 0;
    end
    if (rx_pop) begin
      void'(rx_src.pop_front());
      rx_pop = 0;
    end
    mem_req_ready = (cyc % 4) != 2;
    tx_ready      = !tx_stall && ((cyc % 3) != 1);
    rx_valid      = rx_en && (rx_src.size() > 0);
    rx_data       = rx_valid ? rx_src[0] : 64'd0;
    if (mem_req_valid && mem_req_ready) begin
      if (exp_mem.size() == 0) begin
        chk(0, "R3/R4 unexpected memory request", 64'(mem_req_addr), 64'd0);
      end else begin
        mem_item_t e;
        e = exp_mem.pop_front();
        chk(mem_req_we === e.we && mem_req_addr === e.a, "R3/R4/R5 request addr",
            {23'd0, mem_req_we, mem_req_addr}, {23'd0, e.we, e.a});
        if (e.we) chk(mem_req_wdata === e.d, "R4 write data", mem_req_wdata, e.d);
      end
      if (!mem_req_we) begin
        rd_pend = 1;
        rd_addr = mem_req_addr;
      end
    end
    if (tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk(0, "R3 unexpected tx word", tx_data, 64'd0);
      else begin
        logic [63:0] t;
        t = exp_tx.pop_front();
        chk(tx_data === t, "R3 tx word", tx_data, t);
      end
    end
    if (rx_valid && rx_ready) rx_pop = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd_chk(A_MODE, 64'd0, "R1 mode reset");
    rd_chk(A_RST, 64'h300, "R1 soft reset word");
    rd_chk(A_ST1, 64'd0, "R1 end status");
    rd_chk(A_ST2, 64'd0, "R1 error status");
    rd_chk(A_MSK1, 64'hFFFF_FFFF, "R1 end mask");
    rd_chk(A_MSK2, 64'hFFFF_FFFF, "R1 error mask");
    chk(!busy && !irq_end && !irq_err && !mem_req_valid && !tx_valid && !rx_ready,
        "R1 idle outputs", {busy, irq_end, irq_err, mem_req_valid, tx_valid, rx_ready}, 0);

    // R2 register readback
    wr(A_MODE, 64'hFFFF_0031);
    rd_chk(A_MODE, 64'h1_0031, "R2 mode fields");
    wr(A_MODE, 64'h31);
    wr(A_ADDR, 64'h1000);
    rd_chk(A_ADDR, 64'h1000, "R2 address word");
    wr(A_MSK1, 0);
    wr(A_MSK2, 0);

    // R3 channel 0, incrementing, 4 beats
    xfer_len = 32;
    push_ch0(40'h1000, 4, 1);
    wr(A_CTRL, 1);
    chk(busy === 1'b1, "R3 busy after start", 64'(busy), 1);
    wait_idle();
    chk_drained("R3 all beats seen");
    rd_chk(A_ST1, F0, "R6 end flag ch0");
    chk(irq_end === 1'b1, "R10 irq_end unmasked", 64'(irq_end), 1);

    // R9 clear by writing zero
    wr(A_ST1, 0);
    rd_chk(A_ST1, 0, "R9 end flags cleared");
    chk(irq_end === 1'b0, "R10 irq_end after clear", 64'(irq_end), 0);

    // R4 channel 1, incrementing, 3 beats
    wr(A_MODE, 64'h1_0031);
    wr(A_ADDR, 64'h2000);
    xfer_len = 24;
    push_ch1(40'h2000, 3, 1, 32'hC0DE_0100);
    wr(A_CTRL, 1);
    wait_idle();
    chk_drained("R4 all beats seen");
    rd_chk(A_ST1, F1, "R6 end flag ch1");
    wr(A_ST1, 0);

    // R5 fixed address mode on channel 0
    wr(A_MODE, 64'h30);
    wr(A_ADDR, 64'h3000);
    xfer_len = 16;
    push_ch0(40'h3000, 2, 0);
    wr(A_CTRL, 1);
    wait_idle();
    chk_drained("R5 fixed address beats");
    wr(A_ST1, 0);

    // R6 zero length on channel 1
    wr(A_MODE, 64'h1_0031);
    xfer_len = 0;
    wr(A_CTRL, 1);
    chk(busy === 1'b0, "R6 zero length stays idle", 64'(busy), 0);
    rd_chk(A_ST1, F1, "R6 zero length end flag");
    wr(A_ST1, 0);

    // R7 misaligned start on channel 0
    wr(A_MODE, 64'h31);
    wr(A_ADDR, 64'h4004);
    xfer_len = 16;
    wr(A_CTRL, 1);
    repeat (4) @(negedge clk);
    rd_chk(A_ST2, F0, "R7 error flag ch0");
    rd_chk(A_ST1, 0, "R7 no end flag");
    chk(irq_err === 1'b1, "R10 irq_err unmasked", 64'(irq_err), 1);
    wr(A_ST2, 0);
    rd_chk(A_ST2, 0, "R9 error flags cleared");

    // R8 read error on the second beat
    wr(A_ADDR, 64'h5000);
    err_addr = 40'h5008;
    xfer_len = 24;
    exp_mem.push_back('{1'b0, 40'h5000, 64'd0});
    exp_tx.push_back(mdata(40'h5000));
    exp_mem.push_back('{1'b0, 40'h5008, 64'd0});
    wr(A_CTRL, 1);
    wait_idle();
    chk_drained("R8 stop after error");
    rd_chk(A_ST2, F0, "R8 error flag ch0");
    rd_chk(A_ST1, 0, "R8 no end flag");
    err_addr = 40'hFF_FFFF_FFF8;
    wr(A_MSK2, 64'hFFFF_FFFF);
    chk(irq_err === 1'b0, "R10 irq_err masked", 64'(irq_err), 0);
    wr(A_ST2, 0);

    // R11 soft reset drops a stalled channel 1 transfer
    rx_en = 0;
    wr(A_MODE, 64'h1_0031);
    wr(A_ADDR, 64'h6000);
    xfer_len = 16;
    wr(A_CTRL, 1);
    chk(busy === 1'b1, "R11 transfer waiting", 64'(busy), 1);
    wr(A_RST, 64'h100);
    @(negedge clk);
    chk(busy === 1'b0, "R11 busy dropped", 64'(busy), 0);
    rd_chk(A_ST1, 0, "R11 no end flag on abort");
    wr(A_CTRL, 1);
    chk(busy === 1'b0, "R11 start ignored while held", 64'(busy), 0);
    wr(A_RST, 64'h300);
    rd_chk(A_RST, 64'h300, "R11 reset word restored");
    rx_en = 1;

    // R12 start during busy is ignored; back-pressure on tx
    tx_stall = 1;
    wr(A_MODE, 64'h31);
    wr(A_ADDR, 64'h7000);
    push_ch0(40'h7000, 2, 1);
    wr(A_CTRL, 1);
    wr(A_MODE, 64'h1_0031);
    wr(A_ADDR, 64'h7100);
    wr(A_CTRL, 1);
    repeat (6) @(negedge clk);
    tx_stall = 0;
    wait_idle();
    chk_drained("R12 only first transfer ran");
    rd_chk(A_ST1, F0, "R12 only ch0 end flag");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule